// File: doc/BRIEF.md
# Run-Slice Line Drawing Engine

This block is the command unit of a small graphics coprocessor. Host software splits each line into runs (slices) of pixels along the line's dominant axis and sends one byte per slice. The engine writes that many pixels from the pen position in a straight run along the chosen major axis. It then optionally steps the other coordinate by one. All pixels are written through a simple pixel-write port with one write per clock.

Other bytes are configuration commands. Some take a two-byte operand, sent low byte first: pen X, pen Y, foreground colour, background colour and a 16-bit line pattern. Others take no operand and pick the major axis. Input arrives as a byte stream with a valid/ready handshake. The engine takes no new byte while a slice is being written.

Top module: `slice_line_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `pix_we` is 0. The pen is at (0,0), the major axis is X, the foreground colour is all ones, the background is all zeros and the pattern is all ones.
- R2: A byte whose bits 7:6 are not 00 is a slice. Bits 5:0 give its pixel count, and 0 means 64. The engine writes exactly that many pixels on consecutive clocks, with `pix_we` high throughout. The first write is in the cycle after the byte is accepted.
- R3: Slice code 01 (bits 7:6) adds 1 to the minor-axis coordinate once the run is complete.
- R4: Slice code 10 subtracts 1 from the minor-axis coordinate once the run is complete.
- R5: Slice code 11 leaves the minor-axis coordinate unchanged.
- R6: Each pixel of a run sits one step further along the major axis than the one before. After a run, the major coordinate has grown by the run length. Command byte 0x05 makes X the major axis, and 0x06 makes Y the major axis.
- R7: Command byte 0x00 sets pen X and 0x01 sets pen Y. Each takes a low operand byte and then a high operand byte.
- R8: Command byte 0x02 sets the foreground colour and 0x03 sets the background colour. Each takes a low byte and then a high byte.
- R9: Command byte 0x04 loads the 16-bit pattern, low byte then high byte. Each pixel uses pattern bit 0: 1 writes the foreground colour and 0 writes the background colour. The pattern then rotates right by one bit. The rotation carries on from one slice to the next.
- R10: `cmd_ready` is low from the cycle after a slice byte is accepted until the last pixel of that slice has been written. The low span lasts as many cycles as the slice has pixels. A byte held on the input during that span is taken exactly once, afterwards.
- R11: A command byte with bits 7:6 = 00 and bits 5:0 from 7 to 63 is ignored. It takes no operand bytes, and the next byte is decoded as a command.
- R12: Pen coordinates wrap modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_data | input | 8 | Command or operand byte |
| cmd_ready | output | 1 | Engine accepts a byte this cycle |
| pix_we | output | 1 | Pixel write enable |
| pix_x | output | 16 | Pixel X coordinate |
| pix_y | output | 16 | Pixel Y coordinate |
| pix_color | output | 16 | Pixel colour |

## Verification
Two events resolve on the same clock edge at the end of a run: the final major-axis advance and the minor-axis step. The next slice byte, already held valid while `cmd_ready` is low, is accepted one cycle later. The bench keeps the valid signal asserted across two back-to-back slices. It counts the low-ready cycles and checks that the first pixel of the second slice has both the advanced major coordinate and the stepped minor coordinate. It also checks that the held byte produced exactly one run. Coordinate wrap at 0xFFFF and the 64-pixel length encoding are probed through the same port.

// File: rtl/slice_pkg.sv
package slice_pkg;
    localparam int LEN_W   = 6;
    localparam int CNT_W   = LEN_W + 1;
    localparam int RUN_MAX = 1 << LEN_W;
    localparam int OPND_W  = 16;

    typedef enum logic [1:0] {
        OP_EXT  = 2'b00,
        OP_INC  = 2'b01,
        OP_DEC  = 2'b10,
        OP_HOLD = 2'b11
    } slice_op_e;

    localparam logic [5:0] SUB_SET_X = 6'd0;
    localparam logic [5:0] SUB_SET_Y = 6'd1;
    localparam logic [5:0] SUB_FG    = 6'd2;
    localparam logic [5:0] SUB_BG    = 6'd3;
    localparam logic [5:0] SUB_PAT   = 6'd4;
    localparam logic [5:0] SUB_MAJ_X = 6'd5;
    localparam logic [5:0] SUB_MAJ_Y = 6'd6;

    typedef enum logic [2:0] {
        TGT_X   = 3'd0,
        TGT_Y   = 3'd1,
        TGT_FG  = 3'd2,
        TGT_BG  = 3'd3,
        TGT_PAT = 3'd4
    } reg_tgt_e;

    typedef enum logic [1:0] {
        PS_CMD = 2'd0,
        PS_LO  = 2'd1,
        PS_HI  = 2'd2
    } parse_st_e;
endpackage

// File: rtl/slice_cmd_parser.sv
module slice_cmd_parser
    import slice_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_ok,
    input  logic [7:0]        byte_data,
    output logic              run_start,
    output logic [CNT_W-1:0]  run_len,
    output slice_op_e         run_op,
    output logic              wr_en,
    output reg_tgt_e          wr_tgt,
    output logic [OPND_W-1:0] wr_val,
    output logic              axis_set,
    output logic              axis_y
);
    typedef struct packed {
        parse_st_e  st;
        reg_tgt_e   tgt;
        logic [7:0] lo;
    } pstate_t;

    pstate_t s_q, s_d;
    logic [5:0] sub;
    logic [LEN_W-1:0] len_field;

    always_comb begin
        s_d       = s_q;
        sub       = byte_data[5:0];
        len_field = byte_data[LEN_W-1:0];
        run_start = 1'b0;
        run_len   = (len_field == '0) ? CNT_W'(RUN_MAX) : {1'b0, len_field};
        run_op    = slice_op_e'(byte_data[7:6]);
        wr_en     = 1'b0;
        wr_tgt    = s_q.tgt;
        wr_val    = {byte_data, s_q.lo};
        axis_set  = 1'b0;
        axis_y    = 1'b0;
        if (byte_ok) begin
            case (s_q.st)
                PS_CMD: begin
                    if (byte_data[7:6] != OP_EXT) begin
                        run_start = 1'b1;
                    end else begin
                        case (sub)
                            SUB_SET_X: begin s_d.st = PS_LO; s_d.tgt = TGT_X;   end
                            SUB_SET_Y: begin s_d.st = PS_LO; s_d.tgt = TGT_Y;   end
                            SUB_FG:    begin s_d.st = PS_LO; s_d.tgt = TGT_FG;  end
                            SUB_BG:    begin s_d.st = PS_LO; s_d.tgt = TGT_BG;  end
                            SUB_PAT:   begin s_d.st = PS_LO; s_d.tgt = TGT_PAT; end
                            SUB_MAJ_X: begin axis_set = 1'b1; axis_y = 1'b0; end
                            SUB_MAJ_Y: begin axis_set = 1'b1; axis_y = 1'b1; end
                            default:   ;
                        endcase
                    end
                end
                PS_LO: begin
                    s_d.lo = byte_data;
                    s_d.st = PS_HI;
                end
                PS_HI: begin
                    wr_en  = 1'b1;
                    s_d.st = PS_CMD;
                end
                default: s_d.st = PS_CMD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= PS_CMD;
            s_q.tgt <= TGT_X;
            s_q.lo  <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/slice_run_unit.sv
module slice_run_unit
    import slice_pkg::*;
#(
    parameter int COORD_W = 16
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_start,
    input  logic [CNT_W-1:0]   run_len,
    input  slice_op_e          run_op,
    input  logic               wr_en,
    input  reg_tgt_e           wr_tgt,
    input  logic [OPND_W-1:0]  wr_val,
    input  logic               axis_set,
    input  logic               axis_y,
    output logic               busy,
    output logic [COORD_W-1:0] pen_x,
    output logic [COORD_W-1:0] pen_y
);
    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic               maj_y;
        slice_op_e          op;
    } rstate_t;

    rstate_t s_q, s_d;
    logic [COORD_W-1:0] minor_d;
    logic [COORD_W-1:0] minor_q;

    always_comb begin
        s_d     = s_q;
        minor_q = s_q.maj_y ? s_q.x : s_q.y;
        minor_d = minor_q;
        if (s_q.op == OP_INC)      minor_d = minor_q + 1'b1;
        else if (s_q.op == OP_DEC) minor_d = minor_q - 1'b1;

        if (s_q.busy) begin
            if (s_q.maj_y) s_d.y = s_q.y + 1'b1;
            else           s_d.x = s_q.x + 1'b1;
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                if (s_q.maj_y) s_d.x = minor_d;
                else           s_d.y = minor_d;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else begin
            if (wr_en && wr_tgt == TGT_X) s_d.x = wr_val[COORD_W-1:0];
            if (wr_en && wr_tgt == TGT_Y) s_d.y = wr_val[COORD_W-1:0];
            if (axis_set) s_d.maj_y = axis_y;
            if (run_start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = run_len;
                s_d.op   = run_op;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.busy  <= 1'b0;
            s_q.cnt   <= '0;
            s_q.x     <= '0;
            s_q.y     <= '0;
            s_q.maj_y <= 1'b0;
            s_q.op    <= OP_HOLD;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = s_q.busy;
    assign pen_x = s_q.x;
    assign pen_y = s_q.y;
endmodule

// File: rtl/slice_pattern_unit.sv
module slice_pattern_unit
    import slice_pkg::*;
#(
    parameter int COLOR_W = 16
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_tgt_e           wr_tgt,
    input  logic [OPND_W-1:0]  wr_val,
    input  logic               step,
    output logic [COLOR_W-1:0] color,
    output logic [COLOR_W-1:0] fg_col,
    output logic [COLOR_W-1:0] bg_col
);
    localparam int PAT_W = OPND_W;

    typedef struct packed {
        logic [COLOR_W-1:0] fg;
        logic [COLOR_W-1:0] bg;
        logic [PAT_W-1:0]   pat;
    } cstate_t;

    cstate_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_tgt)
                TGT_FG:  s_d.fg  = wr_val[COLOR_W-1:0];
                TGT_BG:  s_d.bg  = wr_val[COLOR_W-1:0];
                TGT_PAT: s_d.pat = wr_val;
                default: ;
            endcase
        end
        if (step) s_d.pat = {s_q.pat[0], s_q.pat[PAT_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.fg  <= '1;
            s_q.bg  <= '0;
            s_q.pat <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign color  = s_q.pat[0] ? s_q.fg : s_q.bg;
    assign fg_col = s_q.fg;
    assign bg_col = s_q.bg;
endmodule

// File: rtl/slice_line_engine.sv
module slice_line_engine
    import slice_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int COLOR_W = 16
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_data,
    output logic               cmd_ready,
    output logic               pix_we,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y,
    output logic [COLOR_W-1:0] pix_color
);
    logic              busy;
    logic              byte_ok;
    logic              run_start;
    logic [CNT_W-1:0]  run_len;
    slice_op_e         run_op;
    logic              wr_en;
    reg_tgt_e          wr_tgt;
    logic [OPND_W-1:0] wr_val;
    logic              axis_set;
    logic              axis_y;
    logic [COLOR_W-1:0] fg_col;
    logic [COLOR_W-1:0] bg_col;

    assign cmd_ready = !busy;
    assign byte_ok   = cmd_valid && cmd_ready;
    assign pix_we    = busy;

    slice_cmd_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_ok   (byte_ok),
        .byte_data (cmd_data),
        .run_start (run_start),
        .run_len   (run_len),
        .run_op    (run_op),
        .wr_en     (wr_en),
        .wr_tgt    (wr_tgt),
        .wr_val    (wr_val),
        .axis_set  (axis_set),
        .axis_y    (axis_y)
    );

    slice_run_unit #(.COORD_W(COORD_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_start (run_start),
        .run_len   (run_len),
        .run_op    (run_op),
        .wr_en     (wr_en),
        .wr_tgt    (wr_tgt),
        .wr_val    (wr_val),
        .axis_set  (axis_set),
        .axis_y    (axis_y),
        .busy      (busy),
        .pen_x     (pix_x),
        .pen_y     (pix_y)
    );

    slice_pattern_unit #(.COLOR_W(COLOR_W)) u_pat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_tgt (wr_tgt),
        .wr_val (wr_val),
        .step   (busy),
        .color  (pix_color),
        .fg_col (fg_col),
        .bg_col (bg_col)
    );
endmodule

// File: rtl/slice_line_checker.sv
module slice_line_checker #(
    parameter int COORD_W = 16,
    parameter int COLOR_W = 16
)(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic               pix_we,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic [COLOR_W-1:0] pix_color,
    input logic [COLOR_W-1:0] fg,
    input logic [COLOR_W-1:0] bg
);
    localparam int RUN_LIMIT = slice_pkg::RUN_MAX;
    localparam int RC_W      = slice_pkg::CNT_W + 1;

    logic [RC_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (pix_we) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R10: no byte is taken while pixels are being written
    a_r10_no_ready_while_drawing: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> !cmd_ready);

    // R2: a run begins only after a byte was accepted
    a_r2_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_we) |-> $past(cmd_valid && cmd_ready));

    // R2: a run never exceeds the maximum length
    a_r2_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> (run_q < RC_W'(RUN_LIMIT)));

    // R6: consecutive pixels step by one along exactly one axis
    a_r6_major_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_we && $past(pix_we)) |->
            ((pix_x == COORD_W'($past(pix_x) + 1'b1) && $stable(pix_y)) ||
             (pix_y == COORD_W'($past(pix_y) + 1'b1) && $stable(pix_x))));

    // R9: every written colour is the foreground or the background
    a_r9_color_source: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> (pix_color == fg || pix_color == bg));
endmodule

bind slice_line_engine slice_line_checker #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .pix_we    (pix_we),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pix_color (pix_color),
    .fg        (fg_col),
    .bg        (bg_col)
);

// File: tb/slice_line_engine_tb.sv
module slice_line_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CAP_N = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic        cmd_ready;
    logic        pix_we;
    logic [15:0] pix_x, pix_y, pix_color;

    int total = 0;
    int bad = 0;
    int n = 0;
    bit done = 0;
    logic [15:0] cap_x [CAP_N];
    logic [15:0] cap_y [CAP_N];
    logic [15:0] cap_c [CAP_N];

    always #(CLK_PERIOD/2) clk = ~clk;

    slice_line_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .pix_we(pix_we), .pix_x(pix_x), .pix_y(pix_y),
        .pix_color(pix_color)
    );

    always @(negedge clk) begin
        if (pix_we && n < CAP_N) begin
            cap_x[n] = pix_x;
            cap_y[n] = pix_y;
            cap_c[n] = pix_color;
            n = n + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] sub, input logic [15:0] v);
        send(sub);
        send(v[7:0]);
        send(v[15:8]);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic draw(input logic [7:0] b);
        n = 0;
        send(b);
        wait_idle();
    endtask

    task automatic probe(output logic [15:0] px, output logic [15:0] py,
                         output logic [15:0] pc);
        draw(8'hC1);
        px = cap_x[0];
        py = cap_y[0];
        pc = cap_c[0];
    endtask

    task automatic t_reset();
        logic [15:0] px, py, pc;
        chk("R1", "ready after reset", 32'(cmd_ready), 32'd1);
        chk("R1", "we after reset", 32'(pix_we), 32'd0);
        probe(px, py, pc);
        chk("R1", "pen x", 32'(px), 32'd0);
        chk("R1", "pen y", 32'(py), 32'd0);
        chk("R1", "default colour", 32'(pc), 32'hFFFF);
    endtask

    task automatic t_set_pen();
        logic [15:0] px, py, pc;
        set_reg(8'h00, 16'h1234);
        set_reg(8'h01, 16'h0567);
        probe(px, py, pc);
        chk("R7", "set x", 32'(px), 32'h1234);
        chk("R7", "set y", 32'(py), 32'h0567);
    endtask

    task automatic t_run_x_inc();
        logic [15:0] px, py, pc;
        send(8'h05);
        set_reg(8'h02, 16'hABCD);
        set_reg(8'h04, 16'hFFFF);
        set_reg(8'h00, 16'd10);
        set_reg(8'h01, 16'd20);
        draw(8'h45);
        chk("R2", "pixel count len5", 32'(n), 32'd5);
        for (int i = 0; i < 5; i++) begin
            chk("R6", "run x", 32'(cap_x[i]), 32'(10 + i));
            chk("R6", "run y", 32'(cap_y[i]), 32'd20);
            chk("R8", "fg colour", 32'(cap_c[i]), 32'hABCD);
        end
        probe(px, py, pc);
        chk("R6", "major after run", 32'(px), 32'd15);
        chk("R3", "minor +1", 32'(py), 32'd21);
    endtask

    task automatic t_run_y_dec();
        logic [15:0] px, py, pc;
        send(8'h06);
        set_reg(8'h00, 16'd10);
        set_reg(8'h01, 16'd0);
        draw(8'h83);
        chk("R2", "pixel count len3", 32'(n), 32'd3);
        for (int i = 0; i < 3; i++) begin
            chk("R6", "y-major x", 32'(cap_x[i]), 32'd10);
            chk("R6", "y-major y", 32'(cap_y[i]), 32'(i));
        end
        probe(px, py, pc);
        chk("R4", "minor -1", 32'(px), 32'd9);
        chk("R6", "y major after run", 32'(py), 32'd3);
    endtask

    task automatic t_len64_hold();
        logic [15:0] px, py, pc;
        send(8'h05);
        set_reg(8'h00, 16'd0);
        set_reg(8'h01, 16'd7);
        draw(8'hC0);
        chk("R2", "length 0 means 64", 32'(n), 32'd64);
        chk("R2", "last x of 64", 32'(cap_x[63]), 32'd63);
        probe(px, py, pc);
        chk("R6", "major after 64", 32'(px), 32'd64);
        chk("R5", "minor held", 32'(py), 32'd7);
    endtask

    task automatic t_pattern();
        send(8'h05);
        set_reg(8'h02, 16'h00F0);
        set_reg(8'h03, 16'h000F);
        set_reg(8'h04, 16'h0005);
        draw(8'hC3);
        chk("R9", "bit0 fg", 32'(cap_c[0]), 32'h00F0);
        chk("R8", "bit1 bg", 32'(cap_c[1]), 32'h000F);
        chk("R9", "bit2 fg", 32'(cap_c[2]), 32'h00F0);
        draw(8'hC2);
        chk("R9", "rotation carried bit3", 32'(cap_c[0]), 32'h000F);
        chk("R9", "rotation carried bit4", 32'(cap_c[1]), 32'h000F);
    endtask

    task automatic t_ignored();
        set_reg(8'h00, 16'd5);
        set_reg(8'h01, 16'd5);
        send(8'h07);
        send(8'h3F);
        draw(8'hC1);
        chk("R11", "one pixel after ignored", 32'(n), 32'd1);
        chk("R11", "x unchanged", 32'(cap_x[0]), 32'd5);
        chk("R11", "y unchanged", 32'(cap_y[0]), 32'd5);
    endtask

    task automatic t_wrap();
        logic [15:0] px, py, pc;
        send(8'h05);
        set_reg(8'h00, 16'hFFFF);
        set_reg(8'h01, 16'd0);
        draw(8'h82);
        chk("R12", "x before wrap", 32'(cap_x[0]), 32'hFFFF);
        chk("R12", "x after wrap", 32'(cap_x[1]), 32'h0000);
        probe(px, py, pc);
        chk("R12", "x continues", 32'(px), 32'd1);
        chk("R12", "y wraps down", 32'(py), 32'hFFFF);
    endtask

    task automatic t_back_to_back();
        logic [15:0] px, py, pc;
        int lowc;
        send(8'h05);
        set_reg(8'h00, 16'd0);
        set_reg(8'h01, 16'd0);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        n = 0;
        cmd_valid = 1'b1;
        cmd_data  = 8'h43;
        @(negedge clk);
        cmd_data = 8'h42;
        lowc = 0;
        while (!cmd_ready) begin
            lowc++;
            @(negedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        chk("R10", "ready low cycles", 32'(lowc), 32'd3);
        chk("R10", "held byte taken once", 32'(n), 32'd5);
        chk("R10", "second run x", 32'(cap_x[3]), 32'd3);
        chk("R3", "second run y stepped", 32'(cap_y[3]), 32'd1);
        chk("R10", "second run end x", 32'(cap_x[4]), 32'd4);
        probe(px, py, pc);
        chk("R3", "pen after pair x", 32'(px), 32'd5);
        chk("R3", "pen after pair y", 32'(py), 32'd2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_pen();
        t_run_x_inc();
        t_run_y_dec();
        t_len64_hold();
        t_pattern();
        t_ignored();
        t_wrap();
        t_back_to_back();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule